// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block is the combinational arithmetic unit that sits beside the accumulator of a small 8-bit processor. Each evaluation takes two operands, an incoming carry bit and a 3-bit operation code. It returns a result byte, a write-enable for that byte, and candidate next values for the negative, zero, carry and overflow flags. Each flag has its own update-enable, so the flag register outside the block changes only the flags that the operation defines.

The arithmetic path is a single adder. Subtraction feeds it the inverted second operand, and the carry acts as an inverted borrow. This lets the same carry chain both multi-byte additions and multi-byte subtractions. Compare reuses the subtraction path with the carry forced high and discards the difference. The shift path moves operand A one place; the two rotates feed the old carry into the vacated bit. There is no clock: every output settles from the present inputs. The processor around the block owns all register state.

Top module: `alu8_core`

## Requirements
- R1: Add (op 3'd0): `{c_o, result_o}` equals A + B + carry_i as a 9-bit unsigned sum. result_we_o, n_we_o, z_we_o, c_we_o and v_we_o are all 1.
- R2: Subtract (op 3'd1): result_o equals (A − B − (1 − carry_i)) mod 256. c_o is 1 exactly when that difference is not negative (no borrow). All five enables are 1.
- R3: For add and subtract, v_o is 1 exactly when the signed two's-complement result lies outside −128..127; for example 123 + 45 and 123 − (−45) both set it. v_we_o is 1 only for add and subtract.
- R4: Compare (op 3'd2) ignores carry_i. result_o equals (A − B) mod 256 and c_o equals (A ≥ B, unsigned). result_we_o and v_we_o are 0, while n_we_o, z_we_o and c_we_o are 1.
- R5: Shift left (op 3'd3) gives result_o = A shifted left one place with 0 in bit 0. Rotate left (op 3'd4) puts carry_i in bit 0. For both, c_o equals the old bit 7 of A.
- R6: Shift right (op 3'd5) gives result_o = A shifted right one place with 0 in bit 7. Rotate right (op 3'd6) puts carry_i in bit 7. For both, c_o equals the old bit 0 of A.
- R7: Shifts and rotates set result_we_o, n_we_o, z_we_o and c_we_o to 1 and v_we_o to 0.
- R8: Pass (op 3'd7) gives result_o = B, with result_we_o, n_we_o and z_we_o at 1 and c_we_o and v_we_o at 0.
- R9: Whenever n_we_o is 1, n_o equals bit 7 of result_o. Whenever z_we_o is 1, z_o is 1 exactly when result_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (encodings in R1–R8) |
| a_i | input | 8 | First operand (accumulator side; shift source) |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result byte |
| result_we_o | output | 1 | Result should be written back |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |
| n_we_o | output | 1 | Negative flag update enable |
| z_we_o | output | 1 | Zero flag update enable |
| c_we_o | output | 1 | Carry flag update enable |
| v_we_o | output | 1 | Overflow flag update enable |

## Verification
The block holds no state, so a fault in its internal steering shows at the ports in the same evaluation that applies the triggering operation. A wrong operand-inversion or forced-carry decision shows up as a result or carry that is off by one, or by a complemented operand, on subtract and compare only. A wrong decode of enables shows up as a compare that writes its result or a shift that claims an overflow update. Directed corners cover signed overflow in both directions, borrow chaining and carry insertion on each rotate. A broad random sweep covers every operation.

// File: rtl/alu8_pkg.sv
// Shared definitions for the 8-bit accumulator ALU.
// Assumes a 3-bit operation code; encodings are fixed because the
// instruction decoder upstream produces them directly.
package alu8_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_SHL  = 3'd3,
        OP_ROL  = 3'd4,
        OP_SHR  = 3'd5,
        OP_ROR  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_ARITH = 2'd0,
        SRC_SHIFT = 2'd1,
        SRC_PASS  = 2'd2
    } res_src_e;

    // Decoded steering for one operation.
    typedef struct packed {
        logic     invert_b;
        logic     force_cin;
        logic     shift_left;
        logic     rotate;
        res_src_e src;
        logic     res_we;
        logic     n_we;
        logic     z_we;
        logic     c_we;
        logic     v_we;
    } alu_ctrl_t;

endpackage

// File: rtl/alu8_decode.sv
// Operation decoder: turns the operation code into datapath steering
// and per-flag update enables. Purely combinational; assumes the code
// is one of the eight defined values (all are defined).
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output alu_ctrl_t       ctrl_o
);

    // Map each operation onto its steering bits and enables.
    always_comb begin
        ctrl_o = '{invert_b: 1'b0, force_cin: 1'b0, shift_left: 1'b0,
                   rotate: 1'b0, src: SRC_ARITH, res_we: 1'b1,
                   n_we: 1'b1, z_we: 1'b1, c_we: 1'b1, v_we: 1'b0};
        unique case (alu_op_e'(op_i))
            OP_ADD: begin
                ctrl_o.v_we = 1'b1;
            end
            OP_SUB: begin
                ctrl_o.invert_b = 1'b1;
                ctrl_o.v_we     = 1'b1;
            end
            OP_CMP: begin
                ctrl_o.invert_b  = 1'b1;
                ctrl_o.force_cin = 1'b1;
                ctrl_o.res_we    = 1'b0;
            end
            OP_SHL: begin
                ctrl_o.src        = SRC_SHIFT;
                ctrl_o.shift_left = 1'b1;
            end
            OP_ROL: begin
                ctrl_o.src        = SRC_SHIFT;
                ctrl_o.shift_left = 1'b1;
                ctrl_o.rotate     = 1'b1;
            end
            OP_SHR: begin
                ctrl_o.src = SRC_SHIFT;
            end
            OP_ROR: begin
                ctrl_o.src    = SRC_SHIFT;
                ctrl_o.rotate = 1'b1;
            end
            OP_PASS: begin
                ctrl_o.src  = SRC_PASS;
                ctrl_o.c_we = 1'b0;
            end
            default: begin
                ctrl_o.res_we = 1'b0;
                ctrl_o.n_we   = 1'b0;
                ctrl_o.z_we   = 1'b0;
                ctrl_o.c_we   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_addsub.sv
// Shared adder for add, subtract and compare. Subtraction is formed by
// inverting B and using the carry-in as "no borrow". Assumes W >= 2.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         invert_b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   total;

    // Select the true or inverted second operand.
    always_comb b_eff = invert_b_i ? ~b_i : b_i;

    // Ripple sum with carry out in the top bit.
    always_comb total = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};

    // Split the sum; overflow when like-signed inputs give an unlike sign.
    always_comb begin
        sum_o  = total[W-1:0];
        cout_o = total[W];
        ovf_o  = (a_i[MSB] == b_eff[MSB]) && (total[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/alu8_shift.sv
// One-place shifter for operand A. Left or right; the vacated bit takes
// the carry for rotates and zero for plain shifts. The bit pushed out
// becomes the carry. Assumes W >= 2.
module alu8_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  logic         left_i,
    input  logic         rotate_i,
    output logic [W-1:0] out_o,
    output logic         cout_o
);

    logic fill;
    logic [W-1:0] left_v;
    logic [W-1:0] right_v;

    // Choose the bit that enters the vacated position.
    always_comb fill = rotate_i & cin_i;

    // Build both shifted words bit by bit.
    for (genvar i = 0; i < W; i++) begin : g_bits
        if (i == 0) begin : g_lo
            assign left_v[i]  = fill;
            assign right_v[i] = a_i[i+1];
        end else if (i == W - 1) begin : g_hi
            assign left_v[i]  = a_i[i-1];
            assign right_v[i] = fill;
        end else begin : g_mid
            assign left_v[i]  = a_i[i-1];
            assign right_v[i] = a_i[i+1];
        end
    end

    // Pick direction and the bit that falls off.
    always_comb begin
        out_o  = left_i ? left_v : right_v;
        cout_o = left_i ? a_i[W-1] : a_i[0];
    end

endmodule

// File: rtl/alu8_flags.sv
// Derives the sign and zero flags from a finished result word.
module alu8_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0] res_i,
    output logic         neg_o,
    output logic         zero_o
);

    // Sign is the top bit; zero is the NOR of all bits.
    always_comb begin
        neg_o  = res_i[W-1];
        zero_o = ~|res_i;
    end

endmodule

// File: rtl/alu8_core.sv
// Top of the accumulator ALU. Combinational: decodes the operation,
// runs the shared adder and the shifter, selects the result, and emits
// next flag values with per-flag update enables. Holds no state, so it
// has no clock or reset; the surrounding processor registers outputs.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         carry_i,
    output logic [W-1:0] result_o,
    output logic         result_we_o,
    output logic         n_o,
    output logic         z_o,
    output logic         c_o,
    output logic         v_o,
    output logic         n_we_o,
    output logic         z_we_o,
    output logic         c_we_o,
    output logic         v_we_o
);

    alu_ctrl_t    ctrl;
    logic         arith_cin;
    logic [W-1:0] arith_sum;
    logic         arith_cout;
    logic         arith_ovf;
    logic [W-1:0] shift_out;
    logic         shift_cout;

    alu8_decode u_decode (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    // Compare ignores the incoming carry and always subtracts cleanly.
    always_comb arith_cin = ctrl.force_cin | carry_i;

    alu8_addsub #(.W(W)) u_addsub (
        .a_i        (a_i),
        .b_i        (b_i),
        .cin_i      (arith_cin),
        .invert_b_i (ctrl.invert_b),
        .sum_o      (arith_sum),
        .cout_o     (arith_cout),
        .ovf_o      (arith_ovf)
    );

    alu8_shift #(.W(W)) u_shift (
        .a_i      (a_i),
        .cin_i    (carry_i),
        .left_i   (ctrl.shift_left),
        .rotate_i (ctrl.rotate),
        .out_o    (shift_out),
        .cout_o   (shift_cout)
    );

    // Result and carry selection by datapath source.
    always_comb begin
        unique case (ctrl.src)
            SRC_SHIFT: begin
                result_o = shift_out;
                c_o      = shift_cout;
            end
            SRC_PASS: begin
                result_o = b_i;
                c_o      = carry_i;
            end
            default: begin
                result_o = arith_sum;
                c_o      = arith_cout;
            end
        endcase
    end

    alu8_flags #(.W(W)) u_flags (
        .res_i  (result_o),
        .neg_o  (n_o),
        .zero_o (z_o)
    );

    // Overflow value and all enables come straight from decode and adder.
    always_comb begin
        v_o         = arith_ovf;
        result_we_o = ctrl.res_we;
        n_we_o      = ctrl.n_we;
        z_we_o      = ctrl.z_we;
        c_we_o      = ctrl.c_we;
        v_we_o      = ctrl.v_we;
    end

endmodule

// File: rtl/alu8_core_chk.sv
// Assertion checker for alu8_core, attached by bind. The block is
// combinational, so checks are immediate and skip unknown inputs.
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic [2:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         carry_i,
    input logic [W-1:0] result_o,
    input logic         result_we_o,
    input logic         n_o,
    input logic         z_o,
    input logic         c_o,
    input logic         v_o,
    input logic         n_we_o,
    input logic         z_we_o,
    input logic         c_we_o,
    input logic         v_we_o
);

    // Evaluate every property whenever inputs are fully known.
    always_comb begin
        if (!$isunknown({op_i, a_i, b_i, carry_i})) begin
            // R4
            cmp_nowrite_chk: assert (op_i != OP_CMP || (!result_we_o && !v_we_o));
            // R9
            sign_flag_chk: assert (!n_we_o || (n_o == result_o[W-1]));
            // R9
            zero_flag_chk: assert (!z_we_o || (z_o == (result_o == '0)));
            // R5
            left_carry_chk: assert (!(op_i == OP_SHL || op_i == OP_ROL) || (c_o == a_i[W-1]));
            // R6
            right_carry_chk: assert (!(op_i == OP_SHR || op_i == OP_ROR) || (c_o == a_i[0]));
            // R5
            rol_fill_chk: assert (op_i != OP_ROL || (result_o[0] == carry_i));
            // R6
            ror_fill_chk: assert (op_i != OP_ROR || (result_o[W-1] == carry_i));
            // R3
            no_overflow_chk: assert (!v_we_o || (v_o ==
                ((a_i[W-1] == (b_i[W-1] ^ (op_i == OP_SUB))) && (result_o[W-1] != a_i[W-1]))));
            // R8
            pass_value_chk: assert (op_i != OP_PASS || (result_o == b_i && !c_we_o && !v_we_o));
        end
    end

endmodule

bind alu8_core alu8_core_chk #(.W(W)) chk_i (
    .op_i        (op_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .carry_i     (carry_i),
    .result_o    (result_o),
    .result_we_o (result_we_o),
    .n_o         (n_o),
    .z_o         (z_o),
    .c_o         (c_o),
    .v_o         (v_o),
    .n_we_o      (n_we_o),
    .z_we_o      (z_we_o),
    .c_we_o      (c_we_o),
    .v_we_o      (v_we_o)
);

// File: tb/alu8_core_tb_top.sv
// Scoreboard bench: the driver applies a vector on the falling edge and
// queues the expected outcome; the monitor pops and compares on the
// rising edge, half a period after the inputs settle.
module alu8_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op = 3'd7;
    logic [7:0] a = 8'h00;
    logic [7:0] b = 8'h00;
    logic       cin = 1'b0;

    logic [7:0] res;
    logic       res_we, n, z, c, v, n_we, z_we, c_we, v_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] r;
        logic       rwe, n, z, c, v, nwe, zwe, cwe, vwe;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;  // 50 MHz

    alu8_core dut_i (
        .op_i(op), .a_i(a), .b_i(b), .carry_i(cin),
        .result_o(res), .result_we_o(res_we),
        .n_o(n), .z_o(z), .c_o(c), .v_o(v),
        .n_we_o(n_we), .z_we_o(z_we), .c_we_o(c_we), .v_we_o(v_we)
    );

    function automatic int sgn(input logic [7:0] x);
        return x[7] ? int'(x) - 256 : int'(x);
    endfunction

    // Integer reference model from the requirements.
    function automatic exp_t model(input logic [2:0] o, input logic [7:0] x,
                                   input logic [7:0] y, input logic ci);
        exp_t e;
        int s, sv;
        e.rwe = 1; e.nwe = 1; e.zwe = 1; e.cwe = 1; e.vwe = 0; e.v = 0; e.c = 0;
        case (o)
            3'd0: begin // R1, R3
                s = int'(x) + int'(y) + int'(ci);
                e.r = 8'(s); e.c = (s > 255);
                sv = sgn(x) + sgn(y) + int'(ci);
                e.v = (sv > 127 || sv < -128); e.vwe = 1; e.tag = "R1";
            end
            3'd1: begin // R2, R3
                s = int'(x) - int'(y) - (ci ? 0 : 1);
                e.r = 8'(s); e.c = (s >= 0);
                sv = sgn(x) - sgn(y) - (ci ? 0 : 1);
                e.v = (sv > 127 || sv < -128); e.vwe = 1; e.tag = "R2";
            end
            3'd2: begin // R4
                s = int'(x) - int'(y);
                e.r = 8'(s); e.c = (x >= y); e.rwe = 0; e.tag = "R4";
            end
            3'd3: begin e.r = 8'(int'(x) * 2); e.c = (x >= 128); e.tag = "R5"; end
            3'd4: begin e.r = 8'(int'(x) * 2 + int'(ci)); e.c = (x >= 128); e.tag = "R5"; end
            3'd5: begin e.r = 8'(int'(x) / 2); e.c = x[0]; e.tag = "R6"; end
            3'd6: begin e.r = 8'(int'(x) / 2 + 128 * int'(ci)); e.c = x[0]; e.tag = "R6"; end
            default: begin e.r = y; e.cwe = 0; e.tag = "R8"; end
        endcase
        e.n = (e.r >= 128); // R9
        e.z = (e.r == 0);
        return e;
    endfunction

    // Driver: apply one vector and queue its expectation.
    task automatic drive(input logic [2:0] o, input logic [7:0] x,
                         input logic [7:0] y, input logic ci);
        @(negedge clk);
        op = o; a = x; b = y; cin = ci;
        sb_q.push_back(model(o, x, y, ci));
    endtask

    // Monitor: compare the DUT against each queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && sb_q.size() > 0) begin
                exp_t e;
                logic [12:0] act, expv;
                e = sb_q.pop_front();
                act  = {res, res_we, n_we, z_we, c_we, v_we};
                expv = {e.r, e.rwe, e.nwe, e.zwe, e.cwe, e.vwe};
                checks++;
                if (act !== expv ||
                    (e.nwe && n !== e.n) || (e.zwe && z !== e.z) ||
                    (e.cwe && c !== e.c) || (e.vwe && v !== e.v)) begin
                    errors++;
                    $display("FAIL %s op=%0d a=%h b=%h cin=%0d: actual r=%h we=%b nzcv=%b%b%b%b expected r=%h we=%b nzcv=%b%b%b%b",
                             e.tag, op, a, b, cin, res, act[4:0], n, z, c, v,
                             e.r, expv[4:0], e.n, e.z, e.c, e.v);
                end
            end
        end
    end

    // Stimulus: directed corners, then a random sweep over all operations.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(3'd7, 8'h00, 8'h00, 1'b0);   // R8 idle pass, Z set
        drive(3'd0, 8'd123, 8'd45, 1'b0);  // R3 positive overflow
        drive(3'd1, 8'd123, 8'hD3, 1'b1);  // R3 123 - (-45)
        drive(3'd0, 8'hFF, 8'h01, 1'b0);   // R1 carry out, zero
        drive(3'd0, 8'h85, 8'h8B, 1'b1);   // R3 negative overflow
        drive(3'd1, 8'h00, 8'h00, 1'b0);   // R2 borrow-in underflow
        drive(3'd1, 8'h10, 8'h10, 1'b1);   // R2 equal, no borrow
        drive(3'd2, 8'h40, 8'h40, 1'b0);   // R4 equal ignores carry
        drive(3'd2, 8'h3F, 8'h40, 1'b1);   // R4 less than
        drive(3'd2, 8'h80, 8'h7F, 1'b0);   // R4 no V update
        drive(3'd3, 8'h81, 8'h00, 1'b1);   // R5 shl ignores carry
        drive(3'd4, 8'h81, 8'h00, 1'b1);   // R5 rol carry in
        drive(3'd5, 8'h81, 8'h00, 1'b1);   // R6 shr zero fill
        drive(3'd6, 8'h01, 8'h00, 1'b1);   // R6 ror carry in, R7 enables
        drive(3'd6, 8'h01, 8'h00, 1'b0);   // R6 ror to zero, R9
        drive(3'd7, 8'h55, 8'h80, 1'b1);   // R8 pass negative
        for (int i = 0; i < 4000; i++) begin
            drive(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 1'($urandom));
        end
        @(negedge clk);
        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule